// File: doc/BRIEF.md
# Multi-Width Atomic Fetch-and-Add Counter Unit

This block keeps a byte-addressed array of counters and applies one atomic read-modify-write per request. A counter is 1, 2, 4 or 8 bytes wide and is stored little-endian. Counters of different widths may overlap in the same bytes, so a 64-bit counter can be read, or partly modified, through its 8-bit or 16-bit pieces. All counters are zero after reset.

There are three request kinds. A load adds a signed 22-bit increment that is carried in its address word and returns the counter value from before the update. A store either adds its data word to the counter or replaces the counter with it, depending on one address bit, and also returns the prior value. An asynchronous command does the same fetch-and-add as a load, but it delivers the prior value as a 64-bit write to a scratchpad slot instead of a response.

A load or an asynchronous command may ask to wait for an external tag-switch-done pulse before it runs. If that pulse does not arrive within a programmable number of cycles, the request completes with an error and the counter is left unchanged.

The controller is a four-state machine:
- IDLE accepts a request. It goes to RESP if the index is misaligned, to WAIT if tag-wait is set, and to EXEC otherwise.
- WAIT goes to EXEC when `tag_done` is high. It goes to RESP on timeout.
- EXEC performs the read-modify-write and goes to RESP.
- RESP presents the result for one cycle and returns to IDLE.

Top module: `fau_unit`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `sp_we` are 0, and every counter byte reads as zero.
- R2: A load (`req_kind`=0) sign-extends address bits 35:14 from bit 21 to form its increment. It adds the increment modulo the access width and returns the prior value, zero-extended, in `resp_data`. Without tag-wait, `resp_valid` is seen in the second cycle after the accepting edge.
- R3: The size code is 0=8, 1=16, 2=32 and 3=64 bits. For loads and stores it comes from `req_size`; for asynchronous commands it comes from command bits 12:11. The register index is address bits 10:0. Byte index+k holds bits 8k+7:8k of the counter, so overlapping counters of other widths see the same bytes.
- R4: A store (`req_kind`=1) with address bit 13 equal to 0 adds `req_data` to the counter. With bit 13 equal to 1 it overwrites the counter with `req_data`. In both cases the response carries the prior value.
- R5: An index that is not a multiple of the access size in bytes is rejected. The result appears one cycle after acceptance: `resp_err`=1 with `resp_data`=0, or for an asynchronous command `sp_wdata` bit 63 set. No counter changes.
- R6: An asynchronous command (`req_kind`=2) takes its scratchpad slot from bits 63:56. It pulses `sp_we` for one cycle with the prior value on `sp_wdata` and the slot on `sp_slot`, and it never raises `resp_valid`.
- R7: Address bit 13 on a load or asynchronous command holds the operation in WAIT. The operation runs in the cycle after `tag_done` is sampled high, and its result is seen two cycles after that sample.
- R8: If `tag_done` stays low for `cfg_timeout`+1 WAIT cycles, the request completes with the error flag set. A load then has the top bit of its width set in `resp_data` and `resp_err`=1. An asynchronous command has `sp_wdata` bit 63 set. The counter is not modified.
- R9: Requests are served one at a time in arrival order. `req_ready` is low from the accepting edge until the cycle after the result, so back-to-back requests on one counter see each other's updates.
- R10: Arithmetic wraps modulo the access width and never carries into neighbouring bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken on this edge |
| req_kind | input | 2 | 0 load, 1 store, 2 asynchronous command |
| req_size | input | 2 | Size code for loads and stores |
| req_addr | input | 64 | Load/store address word or asynchronous command word |
| req_data | input | 64 | Store data |
| tag_done | input | 1 | Tag switch completed |
| cfg_timeout | input | TMO_W | Tag-wait limit in cycles |
| resp_valid | output | 1 | Load/store result valid |
| resp_err | output | 1 | Misalignment or timeout |
| resp_data | output | 64 | Prior counter value |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_slot | output | 8 | Scratchpad 8-byte slot index |
| sp_wdata | output | 64 | Scratchpad write data, bit 63 is the error flag |

## Verification
The bench first writes one 64-bit pattern and then reads it back through 8-, 16- and 32-bit loads at several offsets. A wrong byte order or a wrong size decode shows up as a wrong slice.

Chains of increments on the same counter are run back to back: positive steps, negative steps, and an all-ones 22-bit increment. These separate a missing sign extension from a stale read. Wrap-around cases at 8 and 16 bits show whether a carry leaks into the next byte.

Misaligned, timed-out and tag-released requests are each followed by a plain load. That load shows whether the counter was left alone. The latency of each request is measured as well, which separates an early or late release from WAIT.

// File: rtl/fau_pkg.sv
package fau_pkg;
    localparam int IDX_W  = 11;
    localparam int WORD_W = 64;
    localparam int INC_LO = 14;
    localparam int INC_HI = 35;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_ASYNC = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EXEC,
        ST_RESP
    } state_e;

    typedef struct packed {
        kind_e              kind;
        logic [1:0]         size;
        logic [IDX_W-1:0]   idx;
        logic [WORD_W-1:0]  operand;
        logic               overwrite;
        logic               tagwait;
        logic [7:0]         slot;
        logic               misaligned;
    } op_t;

    function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] top_bit(input logic [1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_0080;
            2'd1:    return 64'h0000_0000_0000_8000;
            2'd2:    return 64'h0000_0000_8000_0000;
            default: return 64'h8000_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [7:0] byte_en(input logic [1:0] sz);
        case (sz)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/fau_decode.sv
module fau_decode
    import fau_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output op_t               op
);
    localparam int INC_W = INC_HI - INC_LO + 1;

    logic [WORD_W-1:0] incr;
    logic [1:0]        sz;
    logic              is_store;
    logic              unused_bits;

    assign unused_bits = ^{addr[55:INC_HI+1]};
    assign is_store    = (kind == K_STORE);
    assign incr        = {{(WORD_W-INC_W){addr[INC_HI]}}, addr[INC_HI:INC_LO]};
    assign sz          = (kind == K_ASYNC) ? addr[12:11] : size;

    always_comb begin
        op.kind      = kind_e'(kind);
        op.size      = sz;
        op.idx       = addr[IDX_W-1:0];
        op.operand   = is_store ? data : incr;
        op.overwrite = is_store & addr[13];
        op.tagwait   = ~is_store & addr[13];
        op.slot      = addr[63:56];
        unique case (sz)
            2'd0: op.misaligned = 1'b0;
            2'd1: op.misaligned = addr[0];
            2'd2: op.misaligned = |addr[1:0];
            2'd3: op.misaligned = |addr[2:0];
        endcase
    end
endmodule

// File: rtl/fau_array.sv
module fau_array
    import fau_pkg::*;
#(
    parameter int AW = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic              we,
    input  logic [7:0]        be,
    input  logic [WORD_W-1:0] wdata
);
    localparam int DEPTH = 1 << AW;
    localparam int NB    = WORD_W / 8;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < NB; g++) begin : g_rd
        assign rd_word[8*g +: 8] = mem[idx + AW'(g)];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= 8'h00;
        end else if (we) begin
            for (int k = 0; k < NB; k++)
                if (be[k]) mem[idx + AW'(k)] <= wdata[8*k +: 8];
        end
    end
endmodule

// File: rtl/fau_ctrl.sv
module fau_ctrl
    import fau_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  op_t               op,
    input  logic              tag_done,
    input  logic [TMO_W-1:0]  cfg_timeout,
    output logic [IDX_W-1:0]  arr_idx,
    input  logic [WORD_W-1:0] arr_rd,
    output logic              arr_we,
    output logic [7:0]        arr_be,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [WORD_W-1:0] resp_data,
    output logic              sp_we,
    output logic [7:0]        sp_slot,
    output logic [WORD_W-1:0] sp_wdata
);
    state_e            state_q, state_d;
    op_t               op_q;
    logic [TMO_W-1:0]  wait_cnt;
    logic [WORD_W-1:0] res_data;
    logic              res_err;
    logic [WORD_W-1:0] old_val, new_val;
    logic              expired;

    assign expired = (wait_cnt == cfg_timeout);
    assign old_val = arr_rd & width_mask(op_q.size);
    assign new_val = (op_q.overwrite ? op_q.operand : old_val + op_q.operand)
                     & width_mask(op_q.size);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)
                         state_d = op.misaligned ? ST_RESP :
                                   op.tagwait    ? ST_WAIT : ST_EXEC;
            ST_WAIT: if (tag_done)     state_d = ST_EXEC;
                     else if (expired) state_d = ST_RESP;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // request capture, wait counter and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            wait_cnt <= '0;
            res_data <= '0;
            res_err  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q     <= op;
                    wait_cnt <= '0;
                    res_data <= '0;
                    res_err  <= op.misaligned;
                end
                ST_WAIT: if (!tag_done) begin
                    if (expired) begin
                        res_err  <= 1'b1;
                        res_data <= (op_q.kind == K_ASYNC) ? '0 : top_bit(op_q.size);
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_EXEC: begin
                    res_data <= old_val;
                    res_err  <= 1'b0;
                end
                ST_RESP: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        arr_idx    = op_q.idx;
        arr_we     = (state_q == ST_EXEC);
        arr_be     = byte_en(op_q.size);
        arr_wdata  = new_val;
        resp_valid = (state_q == ST_RESP) && (op_q.kind != K_ASYNC);
        sp_we      = (state_q == ST_RESP) && (op_q.kind == K_ASYNC);
        resp_err   = res_err;
        resp_data  = res_data;
        sp_slot    = op_q.slot;
        sp_wdata   = {res_err | res_data[WORD_W-1], res_data[WORD_W-2:0]};
    end

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    // R5
    misalign_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && op.misaligned |=>
            (resp_valid && resp_err) || (sp_we && sp_wdata[WORD_W-1]));
    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT && $stable(cfg_timeout) |-> wait_cnt <= cfg_timeout);
    // R10
    width_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_err |-> (resp_data & ~width_mask(op_q.size)) == '0);
    // R6
    async_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> !sp_we && req_ready);
endmodule

// File: rtl/fau_unit.sv
module fau_unit
    import fau_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_addr,
    input  logic [63:0]       req_data,
    input  logic              tag_done,
    input  logic [TMO_W-1:0]  cfg_timeout,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [63:0]       resp_data,
    output logic              sp_we,
    output logic [7:0]        sp_slot,
    output logic [63:0]       sp_wdata
);
    op_t               op;
    logic [IDX_W-1:0]  arr_idx;
    logic [WORD_W-1:0] arr_rd;
    logic              arr_we;
    logic [7:0]        arr_be;
    logic [WORD_W-1:0] arr_wdata;

    fau_decode i_dec (
        .kind (req_kind),
        .size (req_size),
        .addr (req_addr),
        .data (req_data),
        .op   (op)
    );

    fau_array #(.AW(IDX_W)) i_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (arr_idx),
        .rd_word (arr_rd),
        .we      (arr_we),
        .be      (arr_be),
        .wdata   (arr_wdata)
    );

    fau_ctrl #(.TMO_W(TMO_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .op          (op),
        .tag_done    (tag_done),
        .cfg_timeout (cfg_timeout),
        .arr_idx     (arr_idx),
        .arr_rd      (arr_rd),
        .arr_we      (arr_we),
        .arr_be      (arr_be),
        .arr_wdata   (arr_wdata),
        .resp_valid  (resp_valid),
        .resp_err    (resp_err),
        .resp_data   (resp_data),
        .sp_we       (sp_we),
        .sp_slot     (sp_slot),
        .sp_wdata    (sp_wdata)
    );
endmodule

// File: tb/test_fau_unit.sv
module test_fau_unit;
    localparam int T_CFG = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        tag_done = 1'b0;
    logic [15:0] cfg_timeout = 16'(T_CFG);
    logic        resp_valid, resp_err, sp_we;
    logic [63:0] resp_data, sp_wdata;
    logic [7:0]  sp_slot;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [2048];

    always #4 clk = ~clk;

    fau_unit i_fau_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_size(req_size), .req_addr(req_addr),
        .req_data(req_data), .tag_done(tag_done), .cfg_timeout(cfg_timeout),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data),
        .sp_we(sp_we), .sp_slot(sp_slot), .sp_wdata(sp_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int idx, input logic [21:0] inc,
                                       input bit tw, input int sz, input int slot);
        return {8'(slot), 8'd1, 12'd0, inc, tw, 2'(sz), 11'(idx)};
    endfunction

    // kind: 0 load, 1 store, 2 async; tag_at < 0 means no tag_done pulse
    task automatic issue(input int kind, input int sz_in, input logic [63:0] addr,
                         input logic [63:0] data, input int tag_at, input string req);
        int idx, sz, nb, lat, exp_lat;
        bit tw, mis, err, got;
        logic [63:0] old, opnd, mask, nv, exp_d;
        idx  = int'(addr[10:0]);
        sz   = (kind == 2) ? int'(addr[12:11]) : sz_in;
        nb   = 1 << sz;
        mask = (sz == 3) ? '1 : ((64'd1 << (8*nb)) - 1);
        tw   = (kind != 1) && addr[13];
        mis  = (idx % nb) != 0;
        old  = '0;
        for (int k = 0; k < nb; k++) old |= 64'(model[(idx + k) % 2048]) << (8*k);
        opnd = (kind == 1) ? data : {{42{addr[35]}}, addr[35:14]};
        if (mis) begin
            err = 1; exp_d = '0; exp_lat = 1;
        end else if (tw && tag_at < 0) begin
            err = 1; exp_lat = T_CFG + 2;
            exp_d = (kind == 2) ? '0 : (64'd1 << (8*nb - 1));
        end else begin
            err = 0; exp_d = old;
            exp_lat = tw ? tag_at + 2 : 2;
            nv = ((kind == 1 && addr[13]) ? opnd : old + opnd) & mask;
            for (int k = 0; k < nb; k++) model[(idx + k) % 2048] = nv[8*k +: 8];
        end
        @(negedge clk);
        chk(req_ready == 1'b1, {req, " ready before issue"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_kind = 2'(kind); req_size = 2'(sz_in);
        req_addr = addr; req_data = data;
        @(posedge clk);
        lat = 0; got = 0;
        while (!got && lat < 64) begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
            tag_done = (lat == tag_at);
            if (resp_valid || sp_we) got = 1;
        end
        tag_done = 1'b0;
        chk(got && lat == exp_lat, {req, " latency"}, 64'(lat), 64'(exp_lat));
        if (kind == 2) begin
            chk(sp_we && !resp_valid, {req, " async strobe"}, 64'({sp_we, resp_valid}), 64'b10);
            chk(sp_slot == addr[63:56], {req, " slot"}, 64'(sp_slot), 64'(addr[63:56]));
            chk(sp_wdata == (exp_d | (64'(err) << 63)), {req, " sp data"}, sp_wdata,
                exp_d | (64'(err) << 63));
        end else begin
            chk(resp_valid && resp_err == err, {req, " err flag"}, 64'(resp_err), 64'(err));
            chk(resp_data == exp_d, {req, " data"}, resp_data, exp_d);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !sp_we, "R1 reset outputs",
            64'({req_ready, resp_valid, sp_we}), 64'b100);
        issue(0, 3, mk(40, 22'd0, 0, 0, 0), '0, -1, "R1 zero counter");
        // R4 overwrite, R3 overlapping reads little-endian
        issue(1, 3, mk(0, 22'd0, 1, 0, 0), 64'h1122_3344_5566_7788, -1, "R4 overwrite64");
        issue(0, 0, mk(0, 22'd0, 0, 0, 0), '0, -1, "R3 byte0");
        issue(0, 1, mk(2, 22'd0, 0, 0, 0), '0, -1, "R3 half at 2");
        issue(0, 2, mk(4, 22'd0, 0, 0, 0), '0, -1, "R3 word at 4");
        issue(0, 0, mk(7, 22'd0, 0, 0, 0), '0, -1, "R3 byte7");
        // R2 / R9 back-to-back increments
        issue(0, 3, mk(8, 22'd5, 0, 0, 0), '0, -1, "R2 add +5");
        issue(0, 3, mk(8, 22'h3FFFFD, 0, 0, 0), '0, -1, "R9 add -3");
        issue(0, 3, mk(8, 22'd0, 0, 0, 0), '0, -1, "R9 read back");
        issue(0, 2, mk(16, 22'h3FFFFF, 0, 0, 0), '0, -1, "R2 add -1 word");
        issue(0, 2, mk(16, 22'd0, 0, 0, 0), '0, -1, "R2 sign ext result");
        // R10 wrap, R4 store add
        issue(1, 1, mk(24, 22'd0, 1, 0, 0), 64'hFFFF, -1, "R10 set FFFF");
        issue(1, 1, mk(24, 22'd0, 0, 0, 0), 64'h1, -1, "R4 store add");
        issue(0, 1, mk(24, 22'd0, 0, 0, 0), '0, -1, "R10 half wrapped");
        issue(0, 0, mk(26, 22'd0, 0, 0, 0), '0, -1, "R10 no carry out");
        issue(1, 0, mk(30, 22'd0, 1, 0, 0), 64'h7F, -1, "R4 set 7F");
        issue(0, 0, mk(30, 22'd1, 0, 0, 0), '0, -1, "R10 7F plus 1");
        issue(0, 0, mk(30, 22'd0, 0, 0, 0), '0, -1, "R10 byte 80");
        // R5 misaligned
        issue(0, 2, mk(2, 22'd9, 0, 0, 0), '0, -1, "R5 load32 at 2");
        issue(0, 1, mk(9, 22'd9, 0, 0, 0), '0, -1, "R5 load16 at 9");
        issue(1, 3, mk(4, 22'd0, 1, 0, 0), 64'hDEAD, -1, "R5 store64 at 4");
        issue(2, 0, mk(1, 22'd3, 0, 2, 9), '0, -1, "R5 async32 at 1");
        issue(0, 3, mk(0, 22'd0, 0, 0, 0), '0, -1, "R5 counters unchanged");
        // R6 async
        issue(2, 0, mk(8, 22'd10, 0, 3, 3), '0, -1, "R6 async64");
        issue(2, 0, mk(0, 22'd1, 0, 0, 200), '0, -1, "R6 async8");
        issue(0, 3, mk(8, 22'd0, 0, 0, 0), '0, -1, "R6 async result");
        // R7 tag wait released
        issue(0, 2, mk(16, 22'd2, 1, 0, 0), '0, 3, "R7 load tagwait");
        issue(2, 0, mk(24, 22'd4, 1, 1, 7), '0, 1, "R7 async tagwait");
        issue(0, 2, mk(16, 22'd0, 0, 0, 0), '0, -1, "R7 result");
        // R8 timeouts
        issue(0, 0, mk(30, 22'd5, 1, 0, 0), '0, -1, "R8 load8 timeout");
        issue(2, 0, mk(32, 22'd5, 1, 2, 11), '0, -1, "R8 async32 timeout");
        issue(0, 0, mk(30, 22'd0, 0, 0, 0), '0, -1, "R8 unchanged 8");
        issue(0, 2, mk(32, 22'd0, 0, 0, 0), '0, -1, "R8 unchanged 32");
        // R3 partial update of wider counter
        issue(1, 0, mk(8, 22'd0, 0, 0, 0), 64'h1, -1, "R3 byte add into 64");
        issue(0, 3, mk(8, 22'd0, 0, 0, 0), '0, -1, "R3 overlap read");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule